// File: doc/BRIEF.md
# Framebuffer Span Fill and Copy Engine

This engine writes one 64-bit word per clock into a framebuffer over a run of consecutive word addresses on one scanline. It has two modes. In fill mode every word is built from a 32-bit color register, which is the usual way to clear a color or depth buffer. In copy mode the words come from a small on-chip image buffer of 512 words (4 KB), loaded beforehand through a separate write port, so a stored image can be copied into the framebuffer.

In copy mode an optional alpha test drops transparent pixels. The engine does not rewrite the data for these pixels. It clears the byte enables of each pixel whose alpha is zero, so the framebuffer keeps its old contents at that spot. Pixels are either 16 bits wide (four per word, color 5-5-5 with one alpha bit at bit 0) or 32 bits wide (two per word, alpha in the low byte).

Software sets the configuration inputs and pulses `start`. The engine captures the configuration and drives a valid/ready write stream until the programmed number of words has been accepted. It then reports completion with a single-cycle pulse.

Top module: `fb_span_engine`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy`, `done` and `fb_valid` are low.
- R2: A `start` pulse seen while idle with a nonzero `cfg_len` captures mode, pixel size, alpha enable, color, base, length and offset. `busy` and `fb_valid` are high from the next cycle until the job ends, and `fb_valid` always equals `busy`.
- R3: In fill mode every word carries the 32-bit color in both halves (bits 63:32 and 31:0), with all eight byte enables set.
- R4: The first word goes to `cfg_base`. The address steps by one, modulo 2^ADDR_W, only on a cycle where `fb_valid` and `fb_ready` are both high. While `fb_ready` is low, address, data and enables hold.
- R5: In copy mode the first word is read from buffer entry `cfg_rd_offset`. Each accepted word advances the read index by one, modulo the buffer depth of 512.
- R6: In copy mode with alpha test on and 16-bit pixels, pixel i occupies bits 16i+15:16i. Its byte enables 2i+1 and 2i are cleared when data bit 16i is zero and set otherwise.
- R7: In copy mode with alpha test on and 32-bit pixels, pixel j occupies bits 32j+31:32j. Its byte enables 4j+3 down to 4j are cleared when bits 32j+7:32j are all zero and set otherwise.
- R8: With the alpha test off, and always in fill mode even when the alpha test is on, all eight byte enables are set.
- R9: `done` is high for exactly one cycle, the cycle after the last word of the job is accepted. `busy` falls in that same cycle.
- R10: A `start` pulse while busy, or with `cfg_len` of zero, has no effect. Address, data and job length keep their values, and the pulse does not start a job.
- R11: A cycle with `ld_valid` high stores `ld_data` into buffer entry `ld_idx`. A later copy reads back that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a job with the present configuration |
| cfg_mode | input | 1 | 0 = fill, 1 = copy |
| cfg_pix32 | input | 1 | 0 = 16-bit pixels, 1 = 32-bit pixels |
| cfg_alpha_en | input | 1 | Alpha test enable for copy mode |
| cfg_fill_color | input | 32 | Fill color word |
| cfg_base | input | ADDR_W | First framebuffer word address |
| cfg_len | input | LEN_W | Job length in 64-bit words |
| cfg_rd_offset | input | log2(BUF_DEPTH) | First image buffer entry for copy |
| ld_valid | input | 1 | Image buffer write strobe |
| ld_idx | input | log2(BUF_DEPTH) | Image buffer write index |
| ld_data | input | 64 | Image buffer write data |
| fb_valid | output | 1 | Framebuffer write request |
| fb_ready | input | 1 | Framebuffer accepts the word |
| fb_addr | output | ADDR_W | Framebuffer word address |
| fb_data | output | 64 | Framebuffer write data |
| fb_be | output | 8 | Per-byte write enables |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the engine with ADDR_W of 8 and keeps the default buffer depth of 512 and LEN_W of 16. The narrow address lets a job that starts near 0xFC roll over to address zero. The full-depth buffer lets a copy that starts at entry 508 wrap its read index to entry 0. Image words are seeded so that some 16-bit alpha bits and some 32-bit alpha bytes are zero. Runs with random `fb_ready` then exercise masking and stalls together.

// File: rtl/fbse_pkg.sv
package fbse_pkg;
   localparam int unsigned WORD_W     = 64;
   localparam int unsigned WORD_BYTES = WORD_W / 8;
   localparam int unsigned LANES16    = WORD_W / 16;
   localparam int unsigned LANES32    = WORD_W / 32;
   localparam int unsigned COLOR_W    = 32;

   typedef enum logic {
      MODE_FILL = 1'b0,
      MODE_COPY = 1'b1
   } fbse_mode_e;

   typedef struct packed {
      fbse_mode_e         mode;
      logic               pix32;
      logic               alpha_en;
      logic [COLOR_W-1:0] fill_color;
   } fbse_cfg_t;
endpackage

// File: rtl/fbse_img_buf.sv
module fbse_img_buf
   import fbse_pkg::*;
#(
   parameter int unsigned DEPTH = 512,
   localparam int unsigned IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [WORD_W-1:0] rd_data
);
   logic [WORD_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         mem[wr_idx] <= wr_data;
      end
   end

   assign rd_data = mem[rd_idx];
endmodule

// File: rtl/fbse_span_ctl.sv
module fbse_span_ctl #(
   parameter int unsigned ADDR_W = 24,
   parameter int unsigned LEN_W  = 16,
   parameter int unsigned IDX_W  = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] base,
   input  logic [LEN_W-1:0]  len,
   input  logic [IDX_W-1:0]  offset,
   input  logic              wr_ready,
   output logic              accept_start,
   output logic              busy,
   output logic              done,
   output logic [ADDR_W-1:0] addr,
   output logic [IDX_W-1:0]  ptr
);
   logic [LEN_W-1:0] remain_q;
   logic             last_word;

   assign accept_start = !busy && start && (len != '0);
   assign last_word    = (remain_q == LEN_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         done     <= 1'b0;
         addr     <= '0;
         ptr      <= '0;
         remain_q <= '0;
      end else begin
         done <= 1'b0;
         if (busy) begin
            if (wr_ready) begin
               addr     <= addr + 1'b1;
               ptr      <= ptr + 1'b1;
               remain_q <= remain_q - 1'b1;
               if (last_word) begin
                  busy <= 1'b0;
                  done <= 1'b1;
               end
            end
         end else if (accept_start) begin
            busy     <= 1'b1;
            addr     <= base;
            ptr      <= offset;
            remain_q <= len;
         end
      end
   end
endmodule

// File: rtl/fbse_word_fmt.sv
module fbse_word_fmt
   import fbse_pkg::*;
(
   input  fbse_cfg_t             cfg,
   input  logic [WORD_W-1:0]     buf_word,
   output logic [WORD_W-1:0]     out_data,
   output logic [WORD_BYTES-1:0] out_be
);
   logic [WORD_BYTES-1:0] be16;
   logic [WORD_BYTES-1:0] be32;

   for (genvar g = 0; g < LANES16; g++) begin : g_lane16
      assign be16[2*g +: 2] = {2{buf_word[16*g]}};
   end

   for (genvar g = 0; g < LANES32; g++) begin : g_lane32
      assign be32[4*g +: 4] = {4{|buf_word[32*g +: 8]}};
   end

   always_comb begin
      if (cfg.mode == MODE_COPY) begin
         out_data = buf_word;
      end else begin
         out_data = {LANES32{cfg.fill_color}};
      end
      if (cfg.mode == MODE_FILL || !cfg.alpha_en) begin
         out_be = '1;
      end else if (cfg.pix32) begin
         out_be = be32;
      end else begin
         out_be = be16;
      end
   end
endmodule

// File: rtl/fb_span_engine.sv
module fb_span_engine
   import fbse_pkg::*;
#(
   parameter int unsigned ADDR_W    = 24,
   parameter int unsigned LEN_W     = 16,
   parameter int unsigned BUF_DEPTH = 512,
   localparam int unsigned IDX_W    = $clog2(BUF_DEPTH)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic                  cfg_mode,
   input  logic                  cfg_pix32,
   input  logic                  cfg_alpha_en,
   input  logic [COLOR_W-1:0]    cfg_fill_color,
   input  logic [ADDR_W-1:0]     cfg_base,
   input  logic [LEN_W-1:0]      cfg_len,
   input  logic [IDX_W-1:0]      cfg_rd_offset,
   input  logic                  ld_valid,
   input  logic [IDX_W-1:0]      ld_idx,
   input  logic [WORD_W-1:0]     ld_data,
   output logic                  fb_valid,
   input  logic                  fb_ready,
   output logic [ADDR_W-1:0]     fb_addr,
   output logic [WORD_W-1:0]     fb_data,
   output logic [WORD_BYTES-1:0] fb_be,
   output logic                  busy,
   output logic                  done
);
   initial begin
      assert (BUF_DEPTH >= 2 && (BUF_DEPTH & (BUF_DEPTH - 1)) == 0)
         else $error("BUF_DEPTH must be a power of two");
      assert (BUF_DEPTH * WORD_BYTES <= 4096)
         else $error("image buffer larger than 4 KB");
      assert (ADDR_W >= 2 && LEN_W >= 1)
         else $error("ADDR_W or LEN_W too small");
   end

   fbse_cfg_t         cfg_q;
   logic              accept_start;
   logic [IDX_W-1:0]  rd_ptr;
   logic [WORD_W-1:0] buf_word;
   logic              copy_q;
   logic              pix32_q;
   logic              aen_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (accept_start) begin
         cfg_q.mode       <= fbse_mode_e'(cfg_mode);
         cfg_q.pix32      <= cfg_pix32;
         cfg_q.alpha_en   <= cfg_alpha_en;
         cfg_q.fill_color <= cfg_fill_color;
      end
   end

   assign copy_q  = (cfg_q.mode == MODE_COPY);
   assign pix32_q = cfg_q.pix32;
   assign aen_q   = cfg_q.alpha_en;

   fbse_span_ctl #(
      .ADDR_W (ADDR_W),
      .LEN_W  (LEN_W),
      .IDX_W  (IDX_W)
   ) i_ctl (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .base         (cfg_base),
      .len          (cfg_len),
      .offset       (cfg_rd_offset),
      .wr_ready     (fb_ready),
      .accept_start (accept_start),
      .busy         (busy),
      .done         (done),
      .addr         (fb_addr),
      .ptr          (rd_ptr)
   );

   fbse_img_buf #(
      .DEPTH (BUF_DEPTH)
   ) i_buf (
      .clk     (clk),
      .wr_en   (ld_valid),
      .wr_idx  (ld_idx),
      .wr_data (ld_data),
      .rd_idx  (rd_ptr),
      .rd_data (buf_word)
   );

   fbse_word_fmt i_fmt (
      .cfg      (cfg_q),
      .buf_word (buf_word),
      .out_data (fb_data),
      .out_be   (fb_be)
   );

   assign fb_valid = busy;
endmodule

// File: rtl/fbse_checker.sv
module fbse_checker
   import fbse_pkg::*;
#(
   parameter int unsigned ADDR_W = 24
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  fb_valid,
   input logic                  fb_ready,
   input logic [ADDR_W-1:0]     fb_addr,
   input logic [WORD_W-1:0]     fb_data,
   input logic [WORD_BYTES-1:0] fb_be,
   input logic                  busy,
   input logic                  done,
   input logic                  copy_q,
   input logic                  pix32_q,
   input logic                  aen_q
);
   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      fb_valid && !fb_ready |=> fb_valid && $stable(fb_addr) && $stable(fb_data) && $stable(fb_be)); // R4

   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      fb_valid && fb_ready |=> !fb_valid || fb_addr == $past(fb_addr) + 1'b1); // R4

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9

   AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(fb_valid && fb_ready) && !busy); // R9

   AST_FILL_ALL_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
      fb_valid && !copy_q |-> fb_be == '1); // R3

   AST_NO_ALPHA_ALL_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
      fb_valid && !aen_q |-> fb_be == '1); // R8

   for (genvar g = 0; g < LANES16; g++) begin : g_chk16
      AST_PIXEL16_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
         fb_valid && !pix32_q |-> fb_be[2*g] == fb_be[2*g+1]); // R6
   end

   for (genvar g = 0; g < LANES32; g++) begin : g_chk32
      AST_PIXEL32_QUAD: assert property (@(posedge clk) disable iff (!rst_n)
         fb_valid && pix32_q |-> $countones(fb_be[4*g +: 4]) == 0 || $countones(fb_be[4*g +: 4]) == 4); // R7
   end
endmodule

bind fb_span_engine fbse_checker #(.ADDR_W(ADDR_W)) i_fbse_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .fb_valid (fb_valid),
   .fb_ready (fb_ready),
   .fb_addr  (fb_addr),
   .fb_data  (fb_data),
   .fb_be    (fb_be),
   .busy     (busy),
   .done     (done),
   .copy_q   (copy_q),
   .pix32_q  (pix32_q),
   .aen_q    (aen_q)
);

// File: tb/test_fb_span_engine.sv
`timescale 1ns/1ps
module test_fb_span_engine;
   localparam int AW = 8;
   localparam int DEPTH = 512;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        cfg_mode = 1'b0;
   logic        cfg_pix32 = 1'b0;
   logic        cfg_alpha_en = 1'b0;
   logic [31:0] cfg_fill_color = '0;
   logic [AW-1:0] cfg_base = '0;
   logic [15:0] cfg_len = '0;
   logic [8:0]  cfg_rd_offset = '0;
   logic        ld_valid = 1'b0;
   logic [8:0]  ld_idx = '0;
   logic [63:0] ld_data = '0;
   logic        fb_valid;
   logic        fb_ready = 1'b1;
   logic [AW-1:0] fb_addr;
   logic [63:0] fb_data;
   logic [7:0]  fb_be;
   logic        busy;
   logic        done;

   int checks = 0;
   int errors = 0;
   bit rnd_rdy = 1'b0;

   always #4 clk = ~clk;

   fb_span_engine #(.ADDR_W(AW)) i_fb_span_engine (
      .clk(clk), .rst_n(rst_n), .start(start), .cfg_mode(cfg_mode),
      .cfg_pix32(cfg_pix32), .cfg_alpha_en(cfg_alpha_en),
      .cfg_fill_color(cfg_fill_color), .cfg_base(cfg_base), .cfg_len(cfg_len),
      .cfg_rd_offset(cfg_rd_offset), .ld_valid(ld_valid), .ld_idx(ld_idx),
      .ld_data(ld_data), .fb_valid(fb_valid), .fb_ready(fb_ready),
      .fb_addr(fb_addr), .fb_data(fb_data), .fb_be(fb_be), .busy(busy), .done(done)
   );

   // Reference model state
   logic [63:0] img [DEPTH];
   bit          m_busy = 0;
   bit          m_done = 0;
   int          m_addr = 0;
   int          m_ptr = 0;
   int          m_rem = 0;
   bit          m_copy = 0;
   bit          m_p32 = 0;
   bit          m_aen = 0;
   logic [31:0] m_col = '0;

   function automatic logic [7:0] model_be(bit cp, bit p32, bit aen, logic [63:0] w);
      logic [7:0] r = 8'hFF;
      if (!cp || !aen) return r;
      if (p32) begin
         for (int j = 0; j < 2; j++) if (w[32*j +: 8] == 8'h00) r[4*j +: 4] = 4'h0;
      end else begin
         for (int i = 0; i < 4; i++) if (w[16*i] == 1'b0) r[2*i +: 2] = 2'b00;
      end
      return r;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_done = 0; m_addr = 0; m_ptr = 0; m_rem = 0;
         m_copy = 0; m_p32 = 0; m_aen = 0; m_col = '0;
      end else begin
         if (ld_valid) img[ld_idx] = ld_data;
         m_done = 0;
         if (m_busy) begin
            if (fb_ready) begin
               m_addr = (m_addr + 1) % (1 << AW);
               m_ptr  = (m_ptr + 1) % DEPTH;
               m_rem  = m_rem - 1;
               if (m_rem == 0) begin
                  m_busy = 0;
                  m_done = 1;
               end
            end
         end else if (start && cfg_len != 0) begin
            m_busy = 1; m_addr = int'(cfg_base); m_ptr = int'(cfg_rd_offset);
            m_rem = int'(cfg_len); m_copy = cfg_mode; m_p32 = cfg_pix32;
            m_aen = cfg_alpha_en; m_col = cfg_fill_color;
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
      end
   endtask

   // Compare every cycle, away from the active edge
   always @(negedge clk) begin
      logic [63:0] ew;
      logic [7:0]  eb;
      string       t;
      t = rst_n ? "R2" : "R1";
      chk(busy == m_busy, t, "busy", 64'(busy), 64'(m_busy));
      chk(fb_valid == m_busy, t, "fb_valid", 64'(fb_valid), 64'(m_busy));
      chk(done == m_done, rst_n ? "R9" : "R1", "done", 64'(done), 64'(m_done));
      if (m_busy) begin
         ew = m_copy ? img[m_ptr] : {m_col, m_col};
         eb = model_be(m_copy, m_p32, m_aen, ew);
         chk(fb_addr == AW'(m_addr), "R4", "fb_addr", 64'(fb_addr), 64'(m_addr));
         chk(fb_data == ew, m_copy ? "R5,R11" : "R3", "fb_data", fb_data, ew);
         if (!m_copy)     t = "R3";
         else if (!m_aen) t = "R8";
         else if (m_p32)  t = "R7";
         else             t = "R6";
         chk(fb_be == eb, t, "fb_be", 64'(fb_be), 64'(eb));
      end
      fb_ready <= rnd_rdy ? (($urandom % 4) != 0) : 1'b1;
   end

   task automatic load_buf();
      for (int i = 0; i < DEPTH; i++) begin
         logic [63:0] w;
         @(negedge clk);
         w = {$urandom, $urandom};
         if (i % 3 == 0) w[7:0] = 8'h00;
         if (i % 5 == 0) w[39:32] = 8'h00;
         if (i % 7 == 0) w[16] = 1'b0;
         ld_valid = 1'b1; ld_idx = 9'(i); ld_data = w;
      end
      @(negedge clk);
      ld_valid = 1'b0;
   endtask

   task automatic run_job(input bit md, input bit p32, input bit aen, input logic [31:0] col,
                          input logic [AW-1:0] base, input logic [15:0] len,
                          input logic [8:0] off, input bit rnd, input bit poke);
      @(negedge clk);
      cfg_mode = md; cfg_pix32 = p32; cfg_alpha_en = aen; cfg_fill_color = col;
      cfg_base = base; cfg_len = len; cfg_rd_offset = off; rnd_rdy = rnd;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (poke) begin
         // R10: restart attempt while busy must be ignored
         @(negedge clk);
         cfg_base = base + 8'h40; cfg_len = 16'd2; cfg_fill_color = ~col; cfg_mode = ~md;
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      for (int n = 0; n < 2000 && m_busy; n++) @(negedge clk);
      rnd_rdy = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      load_buf();                                                        // R11
      run_job(1'b0, 1'b0, 1'b0, 32'h1234_ABCD, 8'h10, 16'd5, 9'd0, 1'b0, 1'b0);  // R3
      run_job(1'b0, 1'b1, 1'b1, 32'h00FF_0000, 8'hFC, 16'd7, 9'd3, 1'b1, 1'b0);  // R8 R4 wrap
      run_job(1'b1, 1'b0, 1'b0, 32'h0, 8'h20, 16'd6, 9'd10, 1'b0, 1'b0);        // R5 R8
      run_job(1'b1, 1'b0, 1'b1, 32'h0, 8'h30, 16'd8, 9'd508, 1'b1, 1'b1);       // R6 R5 wrap R10
      run_job(1'b1, 1'b1, 1'b1, 32'h0, 8'h50, 16'd10, 9'd60, 1'b1, 1'b1);       // R7 R10
      run_job(1'b1, 1'b0, 1'b1, 32'h0, 8'h70, 16'd40, 9'd200, 1'b1, 1'b0);      // R6
      run_job(1'b0, 1'b0, 1'b0, 32'hFFFF_0001, 8'h80, 16'd0, 9'd0, 1'b0, 1'b0); // R10 zero length
      run_job(1'b1, 1'b1, 1'b1, 32'h0, 8'h90, 16'd1, 9'd0, 1'b1, 1'b0);         // R9 single word
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule